// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Fetch Control

This block steers instruction fetch around conditional branches in a five-stage in-order pipeline (fetch, decode with operand read, execute, memory, writeback). Each branch is resolved in the decode stage, not in the execute-stage ALU. A dedicated comparator looks at the two raw register-file read values and decides whether the branch is taken. In the same cycle an adder forms the target from the decode-stage PC. The block owns the fetch PC, the decode-stage PC and the decode-stage valid bit.

Only one instruction is in doubt: the one fetched while the branch sits in decode. A static two-bit policy input chooses how that instruction is handled:
- Stall: fetch skips one slot.
- Delayed branch: the slot always executes.
- Predict-not-taken: fetch runs on sequentially, and the slot instruction is squashed when the branch turns out taken.

The block drives a next-PC select code, a fetch-stall flag and a squash flag. The datapath uses these to gate its own pipeline registers.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and id_valid_o is 0.
- R2: When no taken branch and no stall is decided, the following cycle has pc_o equal to the old pc_o plus 4, id_pc_o equal to the old pc_o, and id_valid_o equal to 1.
- R3: br_type_i encodes 00 no branch, 01 branch-if-equal, 10 branch-if-not-equal, and 11 no branch. A valid equal branch is taken when rs_data_i equals rt_data_i. A valid not-equal branch is taken when they differ.
- R4: The target of a taken branch is id_pc_o + 4 + (sign-extended offset_i × 4), and pc_o holds this value on the cycle after the branch is in decode.
- R5: Stall policy is mode_i 00, and mode_i 11 behaves the same way. A valid branch in decode raises fetch_stall_o. On the next cycle id_valid_o is 0, and pc_o is the target if the branch was taken, or otherwise unchanged (the branch PC plus 4).
- R6: Delayed policy is mode_i 01. A valid branch never raises fetch_stall_o or squash_o. The slot instruction is valid in decode on the next cycle, and pc_o moves to the target when the branch is taken.
- R7: Predict-not-taken policy is mode_i 10. A taken branch raises squash_o, id_valid_o is 0 on the next cycle, and pc_o is the target. A not-taken branch costs no cycle.
- R8: When id_valid_o is 0, br_type_i has no effect: fetch_stall_o and squash_o stay 0 and npc_sel_o selects sequential fetch.
- R9: npc_sel_o encodes 00 sequential, 01 hold, 10 branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Slot policy (static between resets) |
| br_type_i | input | 2 | Branch kind of the decode-stage instruction |
| offset_i | input | OFF_W | Signed word offset of the decode-stage branch |
| rs_data_i | input | DATA_W | First register-file read value |
| rt_data_i | input | DATA_W | Second register-file read value |
| pc_o | output | PC_W | Fetch PC this cycle |
| id_pc_o | output | PC_W | PC of the instruction in decode |
| id_valid_o | output | 1 | Decode-stage instruction valid |
| npc_sel_o | output | 2 | Next-PC select code |
| fetch_stall_o | output | 1 | Current fetch slot is discarded |
| squash_o | output | 1 | Wrongly fetched slot instruction is invalidated |

## Verification
The bench builds the block with its defaults: a 32-bit PC, 32-bit register data and a 16-bit offset. With these widths the extreme offsets +32767 and −32768 push the target far in both directions, and a backward branch can wrap the PC. The bench runs each of the four mode codes with a mix of branch kinds and operand pairs, equal about one time in four. That mix produces back-to-back branches, branches in delay slots and branches arriving in a bubble. Those are the cases where a squashed branch must stay silent.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'b00,
    NPC_HOLD   = 2'b01,
    NPC_TARGET = 2'b10
  } npc_sel_e;

  typedef enum logic [1:0] {
    POL_STALL  = 2'b00,
    POL_DELAY  = 2'b01,
    POL_PNT    = 2'b10,
    POL_STALL2 = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_RSVD = 2'b11
  } br_kind_e;
endpackage

// File: rtl/bh_branch_resolve.sv
module bh_branch_resolve
  import bh_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              id_valid_i,
  input  logic [PC_W-1:0]   id_pc_i,
  input  logic [1:0]        br_type_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] rs_data_i,
  input  logic [DATA_W-1:0] rt_data_i,
  output logic              is_branch_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o
);
  localparam int EXT_W = PC_W - OFF_W - 2;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  br_kind_e kind;
  logic     same;
  logic [PC_W-1:0] disp;

  assign kind = br_kind_e'(br_type_i);
  assign same = (rs_data_i == rt_data_i);

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
    end else begin : g_trunc
      assign disp = PC_W'({offset_i, 2'b00});
    end
  endgenerate

  always_comb begin
    is_branch_o = 1'b0;
    taken_o     = 1'b0;
    if (id_valid_i) begin
      unique case (kind)
        BR_EQ: begin is_branch_o = 1'b1; taken_o = same;  end
        BR_NE: begin is_branch_o = 1'b1; taken_o = !same; end
        default: ;
      endcase
    end
  end

  assign target_o = id_pc_i + STEP + disp;
endmodule

// File: rtl/bh_policy.sv
module bh_policy
  import bh_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       is_branch_i,
  input  logic       taken_i,
  output logic [1:0] npc_sel_o,
  output logic       stall_o,
  output logic       squash_o,
  output logic       slot_valid_o
);
  policy_e  pol;
  npc_sel_e sel;

  assign pol = policy_e'(mode_i);

  always_comb begin
    sel      = NPC_SEQ;
    stall_o  = 1'b0;
    squash_o = 1'b0;
    unique case (pol)
      POL_DELAY: begin
        if (taken_i) sel = NPC_TARGET;
      end
      POL_PNT: begin
        if (taken_i) begin
          sel      = NPC_TARGET;
          squash_o = 1'b1;
        end
      end
      default: begin
        // mode 11 aliases stall
        if (is_branch_i) begin
          stall_o = 1'b1;
          sel     = taken_i ? NPC_TARGET : NPC_HOLD;
        end
      end
    endcase
  end

  assign npc_sel_o    = sel;
  assign slot_valid_o = !(stall_o || squash_o);

  always_comb begin
    assert_stall_squash_excl_R6: assert (!(stall_o && squash_o));
  end
endmodule

// File: rtl/bh_fetch_state.sv
module bh_fetch_state
  import bh_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      npc_sel_i,
  input  logic [PC_W-1:0] target_i,
  input  logic            slot_valid_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] id_pc_o,
  output logic            id_valid_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0] pc_q, id_pc_q, pc_d;
  logic            id_valid_q;

  always_comb begin
    unique case (npc_sel_e'(npc_sel_i))
      NPC_TARGET: pc_d = target_i;
      NPC_HOLD:   pc_d = pc_q;
      default:    pc_d = pc_q + STEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      id_pc_q    <= '0;
      id_valid_q <= 1'b0;
    end else begin
      pc_q       <= pc_d;
      id_pc_q    <= pc_q;
      id_valid_q <= slot_valid_i;
    end
  end

  assign pc_o       = pc_q;
  assign id_pc_o    = id_pc_q;
  assign id_valid_o = id_valid_q;

  assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_i == NPC_SEQ) |=> (pc_o == $past(pc_o) + STEP));
  assert_hold_pc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_i == NPC_HOLD) |=> (pc_o == $past(pc_o)));
  assert_target_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_i == NPC_TARGET) |=> (pc_o == $past(target_i)));
  assert_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_valid_i |=> !id_valid_o);
endmodule

// File: rtl/branch_hazard_ctrl.sv
module branch_hazard_ctrl
  import bh_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        br_type_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] rs_data_i,
  input  logic [DATA_W-1:0] rt_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   id_pc_o,
  output logic              id_valid_o,
  output logic [1:0]        npc_sel_o,
  output logic              fetch_stall_o,
  output logic              squash_o
);
  logic            is_branch, taken, slot_valid;
  logic [PC_W-1:0] target;

  bh_branch_resolve #(.PC_W(PC_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) i_resolve (
    .id_valid_i (id_valid_o),
    .id_pc_i    (id_pc_o),
    .br_type_i  (br_type_i),
    .offset_i   (offset_i),
    .rs_data_i  (rs_data_i),
    .rt_data_i  (rt_data_i),
    .is_branch_o(is_branch),
    .taken_o    (taken),
    .target_o   (target)
  );

  bh_policy i_policy (
    .mode_i      (mode_i),
    .is_branch_i (is_branch),
    .taken_i     (taken),
    .npc_sel_o   (npc_sel_o),
    .stall_o     (fetch_stall_o),
    .squash_o    (squash_o),
    .slot_valid_o(slot_valid)
  );

  bh_fetch_state #(.PC_W(PC_W)) i_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .npc_sel_i   (npc_sel_o),
    .target_i    (target),
    .slot_valid_i(slot_valid),
    .pc_o        (pc_o),
    .id_pc_o     (id_pc_o),
    .id_valid_o  (id_valid_o)
  );

  assert_quiet_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_o |-> (!fetch_stall_o && !squash_o && npc_sel_o == NPC_SEQ));
  assert_delay_keeps_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == POL_DELAY && is_branch) |=> id_valid_o);
  assert_squash_redirect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (npc_sel_o == NPC_TARGET));
  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && !id_valid_o));
endmodule

// File: tb/test_branch_hazard_ctrl.sv
module test_branch_hazard_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [1:0]  mode;
  logic [1:0]  br_type;
  logic [15:0] offset;
  logic [31:0] rs_data, rt_data;
  logic [31:0] pc, id_pc;
  logic        id_valid, fetch_stall, squash;
  logic [1:0]  npc_sel;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] m_pc, m_id_pc;
  bit          m_id_valid;
  bit          m_was_target;

  always #5 clk = ~clk;

  branch_hazard_ctrl i_branch_hazard_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .br_type_i(br_type),
    .offset_i(offset), .rs_data_i(rs_data), .rt_data_i(rt_data),
    .pc_o(pc), .id_pc_o(id_pc), .id_valid_o(id_valid), .npc_sel_o(npc_sel),
    .fetch_stall_o(fetch_stall), .squash_o(squash)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic pick_stim();
    int r;
    r = $urandom % 10;
    br_type = (r < 4) ? 2'd0 : 2'(1 + ($urandom % 3));
    r = $urandom % 6;
    case (r)
      0: offset = 16'h7fff;
      1: offset = 16'h8000;
      2: offset = 16'hffff;
      3: offset = 16'h0000;
      default: offset = 16'($urandom % 64) - 16'd32;
    endcase
    rs_data = 32'($urandom % 4);
    rt_data = 32'($urandom % 4);
  endtask

  task automatic run_mode(int md, int cycles);
    rst_ni  = 1'b0;
    mode    = 2'(md);
    br_type = 2'd0;
    offset  = '0;
    rs_data = '0;
    rt_data = '0;
    @(negedge clk);
    #1;
    chk("R1", "pc in reset", pc, 0);
    chk("R1", "id_valid in reset", id_valid, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_pc = '0; m_id_pc = '0; m_id_valid = 0; m_was_target = 0;
    for (int i = 0; i < cycles; i++) begin
      bit          isbr, cond, tk, e_stall, e_sq;
      int          pol, so;
      logic [1:0]  e_sel;
      logic [31:0] tgt, n_pc;
      pick_stim();
      #1;
      pol  = (md == 3) ? 0 : md;
      isbr = m_id_valid && (br_type == 2'd1 || br_type == 2'd2);
      cond = (br_type == 2'd1) ? (rs_data == rt_data) : (rs_data != rt_data);
      tk   = isbr && cond;
      so   = $signed(offset);
      tgt  = m_id_pc + 32'd4 + 32'(so * 4);
      e_stall = (pol == 0) && isbr;
      e_sq    = (pol == 2) && tk;
      e_sel   = tk ? 2'd2 : (e_stall ? 2'd1 : 2'd0);

      chk(m_was_target ? "R4" : "R2", "pc", pc, m_pc);
      chk("R2", "id_pc", id_pc, m_id_pc);
      chk(md == 1 ? "R6" : "R2", "id_valid", id_valid, m_id_valid);
      if (!m_id_valid && br_type != 2'd0) begin
        chk("R8", "stall on squashed branch", fetch_stall, 0);
        chk("R8", "squash on squashed branch", squash, 0);
        chk("R8", "sel on squashed branch", npc_sel, 0);
      end else begin
        chk(md == 3 ? "R5 alias" : "R5", "fetch_stall", fetch_stall, e_stall);
        chk("R7", "squash", squash, e_sq);
        chk(isbr ? "R3" : "R9", "npc_sel", npc_sel, e_sel);
      end

      n_pc = tk ? tgt : (e_stall ? m_pc : m_pc + 32'd4);
      m_id_pc      = m_pc;
      m_pc         = n_pc;
      m_id_valid   = !(e_stall || e_sq);
      m_was_target = tk;
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int md = 0; md < 4; md++) run_mode(md, 400);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule